// File: doc/BRIEF.md
# Multi-channel DAC serial load controller

This block is the digital front end of a four-channel, 16-bit converter. A host shifts command frames into it over a three-wire serial port. The port has a serial clock, an active-low frame select and a data line. The frame select and the serial clock are oversampled in the system clock domain, which must run at least four times faster than the serial clock. A frame carries a command, a channel number and a 16-bit straight-binary code. Each channel owns an output-code register that feeds its converter.

An update is either immediate, applied when the frame ends, or collective. In the collective case the host raises `hold_load` and writes the channels it wants to change. It then lowers `hold_load`, and all staged channels move at once. While held, only the first write to a channel after `hold_load` rises is kept for the transfer.

Frames can carry an optional CRC byte. A `clr` strobe forces a programmable clear code onto the selected channels. After reset, a busy window keeps early frames out while the converter settles.

Top module: `dacld_top`

## Requirements
- R1: A frame is shifted in most significant bit first, with one bit taken on each falling edge of `ser_clk` while `ser_sel_n` is low. The frame is judged when `ser_sel_n` rises. In a 24-bit frame, bits [23:21] are ignored, bits [20:18] are the command (000 writes a channel code, 001 writes the clear code), bits [17:16] name the channel and bits [15:0] are the code.
- R2: With `crc_en` high, a frame is 32 bits. The last 8 bits are a CRC-8 over the 24 frame bits, MSB first, with generator x^8+x^2+x+1 (0x07) and an initial value of zero. A frame whose check byte matches is applied like a plain 24-bit frame.
- R3: A frame whose bit count is not exactly 24 (`crc_en` low) or exactly 32 (`crc_en` high) is discarded and changes no output.
- R4: A correctly sized frame whose check byte does not match is discarded. It sets `crc_err`, which then stays high until reset. `crc_err` is low after reset.
- R5: If `hold_load` is low when a channel-write frame ends, that channel's output code takes the frame's code.
- R6: While `hold_load` is high, channel writes do not change any output. Only the first write to each channel after `hold_load` rises is staged, and later writes to that channel are not staged.
- R7: When `hold_load` falls, every channel with a staged code takes it in the same cycle, channels with nothing staged keep their codes, and all staging is emptied.
- R8: A one-cycle `clr` pulse loads the clear code into every channel whose `clr_mask` bit is set. The clear code is zero after reset. If a `clr` pulse and a `hold_load` release land in the same cycle, the clear wins on the masked channels.
- R9: After reset, all output codes are zero, and `busy` is high for exactly BUSY_CYCLES clock cycles and then stays low. A frame that ends while `busy` is high is discarded.
- R10: Frames with a command other than 000 or 001 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data taken on its falling edge |
| ser_sel_n | input | 1 | Active-low frame select; rising edge ends the frame |
| ser_din | input | 1 | Serial data, MSB first |
| crc_en | input | 1 | High: frames carry a trailing CRC-8 byte |
| hold_load | input | 1 | High: stage writes; falling edge transfers all staged codes |
| clr | input | 1 | Clear strobe |
| clr_mask | input | 4 | Per-channel clear enable, bit n for channel n |
| dac_code | output | 64 | Output codes, channel n in bits [16n+15:16n] |
| busy | output | 1 | High during the post-reset hold-off window |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The clear strobe and the release of `hold_load` can both reach the output registers on the same clock edge. The bench provokes this by timing `clr` to arrive in the cycle where the synchronised `hold_load` falling edge is seen. One staged channel is covered by `clr_mask` and another staged channel is not. The result is correct only if the masked channel shows the clear code, the unmasked one shows its staged code, and a later release transfers nothing stale.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int FRAME_W = 24;
    localparam int CHK_W   = 8;
    localparam int CODE_W  = 16;
    localparam int CH_W    = 2;
    localparam int N_CH    = 1 << CH_W;
    localparam int CMD_W   = 3;

    localparam logic [CMD_W-1:0] CMD_DATA    = 3'b000;
    localparam logic [CMD_W-1:0] CMD_CLRCODE = 3'b001;

    typedef struct packed {
        logic              vld;
        logic [CMD_W-1:0]  cmd;
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
    } frame_t;

    // bit-serial CRC-8, generator 0x07, zero start, MSB first
    function automatic logic [CHK_W-1:0] crc8(input logic [FRAME_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = FRAME_W - 1; i >= 0; i--) begin
            fb = c[CHK_W-1] ^ d[i];
            c  = {c[CHK_W-2:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

endpackage

// File: rtl/dacld_serial_rx.sv
module dacld_serial_rx
    import dacld_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ser_clk,
    input  logic   ser_sel_n,
    input  logic   ser_din,
    input  logic   crc_en,
    input  logic   busy,
    output frame_t frm,
    output logic   crc_err
);
    localparam int LEN_CHK = FRAME_W + CHK_W;
    localparam int CNT_W   = $clog2(LEN_CHK + 2);

    logic [2:0]         sck_s, sel_s;
    logic [1:0]         din_s;
    logic [LEN_CHK-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               sck_fall, sel_fall, sel_rise, active;
    logic               len_ok, chk_ok, take;

    assign sck_fall = sck_s[2] & ~sck_s[1];
    assign sel_fall = sel_s[2] & ~sel_s[1];
    assign sel_rise = ~sel_s[2] & sel_s[1];
    assign active   = ~sel_s[1];

    always_comb begin
        len_ok = crc_en ? (cnt == CNT_W'(LEN_CHK)) : (cnt == CNT_W'(FRAME_W));
        chk_ok = !crc_en || (crc8(sh[LEN_CHK-1:CHK_W]) == sh[CHK_W-1:0]);
        take   = sel_rise && len_ok && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s   <= '0;
            sel_s   <= '1;
            din_s   <= '0;
            sh      <= '0;
            cnt     <= '0;
            frm     <= '0;
            crc_err <= 1'b0;
        end else begin
            sck_s <= {sck_s[1:0], ser_clk};
            sel_s <= {sel_s[1:0], ser_sel_n};
            din_s <= {din_s[0], ser_din};
            if (sel_fall) begin
                cnt <= '0;
            end else if (sck_fall && active) begin
                sh <= {sh[LEN_CHK-2:0], din_s[1]};
                if (cnt != CNT_W'(LEN_CHK + 1)) cnt <= cnt + 1'b1;
            end
            frm.vld  <= take && chk_ok;
            frm.cmd  <= crc_en ? sh[28:26] : sh[20:18];
            frm.ch   <= crc_en ? sh[25:24] : sh[17:16];
            frm.code <= crc_en ? sh[23:8]  : sh[15:0];
            if (take && !chk_ok) crc_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) crc_err |=> crc_err); // R4
    AST_LEN_DROP: assert property (@(posedge clk) disable iff (rst) (sel_rise && !len_ok) |=> !frm.vld); // R3

endmodule

// File: rtl/dacld_busy_timer.sv
module dacld_busy_timer #(
    parameter int BUSY_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)               left <= BW'(BUSY_CYCLES);
        else if (left != '0)   left <= left - 1'b1;
    end

    assign busy = (left != '0);

    AST_BUSY_ONCE: assert property (@(posedge clk) disable iff (rst) !busy |=> !busy); // R9

endmodule

// File: rtl/dacld_chan_bank.sv
module dacld_chan_bank
    import dacld_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  frame_t                   frm,
    input  logic                     hold_load,
    input  logic                     clr,
    input  logic [N_CH-1:0]          clr_mask,
    output logic [N_CH*CODE_W-1:0]   dac_code
);
    logic [2:0]        hs;
    logic              hold_q, rel;
    logic [CODE_W-1:0] out_q [N_CH];
    logic [CODE_W-1:0] stg_q [N_CH];
    logic [N_CH-1:0]   stg_vld, wr_hit;
    logic [CODE_W-1:0] clr_code_q;

    assign hold_q = hs[1];
    assign rel    = hs[2] & ~hs[1];

    always_comb begin
        for (int i = 0; i < N_CH; i++)
            wr_hit[i] = frm.vld && (frm.cmd == CMD_DATA) && (frm.ch == CH_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs         <= '0;
            clr_code_q <= '0;
            stg_vld    <= '0;
            for (int i = 0; i < N_CH; i++) begin
                out_q[i] <= '0;
                stg_q[i] <= '0;
            end
        end else begin
            hs <= {hs[1:0], hold_load};
            if (frm.vld && frm.cmd == CMD_CLRCODE) clr_code_q <= frm.code;
            for (int i = 0; i < N_CH; i++) begin
                // priority: clear, then collective transfer, then direct write
                if (clr && clr_mask[i])        out_q[i] <= clr_code_q;
                else if (rel && stg_vld[i])    out_q[i] <= stg_q[i];
                else if (wr_hit[i] && !hold_q) out_q[i] <= frm.code;
                if (rel) begin
                    stg_vld[i] <= 1'b0;
                end else if (wr_hit[i] && hold_q && !stg_vld[i]) begin
                    stg_q[i]   <= frm.code;
                    stg_vld[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign dac_code[g*CODE_W +: CODE_W] = out_q[g];

        AST_IMM_WRITE: assert property (@(posedge clk) disable iff (rst) (wr_hit[g] && !hold_q && !clr && !rel) |=> out_q[g] == $past(frm.code)); // R5
        AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst) (hold_q && !(clr && clr_mask[g])) |=> $stable(out_q[g])); // R6
        AST_CLR_LOAD: assert property (@(posedge clk) disable iff (rst) (clr && clr_mask[g]) |=> out_q[g] == $past(clr_code_q)); // R8
    end

endmodule

// File: rtl/dacld_top.sv
module dacld_top
    import dacld_pkg::*;
#(
    parameter int BUSY_CYCLES = 10000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_sel_n,
    input  logic                   ser_din,
    input  logic                   crc_en,
    input  logic                   hold_load,
    input  logic                   clr,
    input  logic [N_CH-1:0]        clr_mask,
    output logic [N_CH*CODE_W-1:0] dac_code,
    output logic                   busy,
    output logic                   crc_err
);
    frame_t frm;

    dacld_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .busy (busy)
    );

    dacld_serial_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_sel_n (ser_sel_n),
        .ser_din   (ser_din),
        .crc_en    (crc_en),
        .busy      (busy),
        .frm       (frm),
        .crc_err   (crc_err)
    );

    dacld_chan_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .frm       (frm),
        .hold_load (hold_load),
        .clr       (clr),
        .clr_mask  (clr_mask),
        .dac_code  (dac_code)
    );

    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst) busy |=> !frm.vld); // R9

endmodule

// File: tb/test_dacld_top.sv
module test_dacld_top;
    localparam int CLK_P = 10;
    localparam int BUSY  = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic        crc_en = 1'b0, hold_load = 1'b0, clr = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic [63:0] dac_code;
    logic        busy, crc_err;

    int vecs = 0, errs = 0, busy_cnt = 0;
    bit done = 0;

    logic [15:0] exp_out [4];
    logic [15:0] exp_stg [4];
    logic [3:0]  exp_sv;
    logic [15:0] exp_clr;

    dacld_top #(.BUSY_CYCLES(BUSY)) i_dacld_top (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .crc_en(crc_en), .hold_load(hold_load), .clr(clr),
        .clr_mask(clr_mask), .dac_code(dac_code), .busy(busy), .crc_err(crc_err)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (!rst && busy) busy_cnt++;

    // polynomial long division of {data, 8'h00} by 0x107
    function automatic logic [7:0] crc_ref(input logic [23:0] d);
        logic [31:0] r;
        r = {d, 8'h00};
        for (int k = 31; k >= 8; k--)
            if (r[k]) r[k -: 9] = r[k -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    function automatic logic [23:0] mkw(input logic [2:0] cmd, input logic [1:0] ch, input logic [15:0] code);
        logic [2:0] rsv;
        rsv = 3'($urandom);
        return {rsv, cmd, ch, code};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) chk(req, 64'(dac_code[c*16 +: 16]), 64'(exp_out[c]));
    endtask

    task automatic send(input logic [31:0] w, input int n);
        ser_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = n - 1; k >= 0; k--) begin
            ser_clk = 1'b1; ser_din = w[k];
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ser_sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic model(input logic [23:0] w);
        logic [1:0] ch;
        ch = w[17:16];
        if (w[20:18] == 3'b000) begin
            if (!hold_load) exp_out[ch] = w[15:0];
            else if (!exp_sv[ch]) begin exp_stg[ch] = w[15:0]; exp_sv[ch] = 1'b1; end
        end else if (w[20:18] == 3'b001) exp_clr = w[15:0];
    endtask

    task automatic send_good(input logic [23:0] w);
        if (crc_en) send({w, crc_ref(w)}, 32);
        else        send({8'h00, w}, 24);
        model(w);
    endtask

    task automatic hold_on();
        hold_load = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic release_hold();
        hold_load = 1'b0;
        repeat (8) @(negedge clk);
        for (int c = 0; c < 4; c++) if (exp_sv[c]) exp_out[c] = exp_stg[c];
        exp_sv = '0;
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        clr_mask = m;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < 4; c++) if (m[c]) exp_out[c] = exp_clr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [23:0] w;
        void'($urandom(32'h00C0FFEE));
        for (int c = 0; c < 4; c++) begin exp_out[c] = '0; exp_stg[c] = '0; end
        exp_sv = '0; exp_clr = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state and busy window; R4: flag low after reset
        chk("R9 busy after reset", 64'(busy), 64'd1);
        chk("R4 crc_err after reset", 64'(crc_err), 64'd0);
        check_all("R9 reset codes");
        send({8'h00, mkw(3'b000, 2'd1, 16'hBEEF)}, 24);
        chk("R9 busy still high", 64'(busy), 64'd1);
        check_all("R9 frame during busy discarded");
        while (busy) @(negedge clk);
        chk("R9 busy length", 64'((busy_cnt >= BUSY - 1) && (busy_cnt <= BUSY + 1)), 64'd1);

        // R1/R5: direct write
        send_good(mkw(3'b000, 2'd0, 16'h1234));
        check_all("R1 R5 direct write ch0");
        send_good(mkw(3'b000, 2'd3, 16'h8001));
        check_all("R5 direct write ch3");

        // R10: unknown command
        send({8'h00, mkw(3'b011, 2'd0, 16'hFFFF)}, 24);
        check_all("R10 unknown command ignored");

        // R3: wrong lengths
        w = mkw(3'b000, 2'd2, 16'h5555);
        send({8'h00, w}, 23);
        check_all("R3 23-bit frame");
        send({w, 8'hA5}, 25);
        check_all("R3 25-bit frame");

        // R2/R4: check byte
        crc_en = 1'b1;
        send_good(mkw(3'b000, 2'd2, 16'h0BAD));
        check_all("R2 good crc frame");
        chk("R4 no error on good crc", 64'(crc_err), 64'd0);
        send({8'h00, mkw(3'b000, 2'd2, 16'h7777)}, 24);
        check_all("R3 24 bits with crc on");
        w = mkw(3'b000, 2'd1, 16'h4321);
        send({w, crc_ref(w) ^ 8'h10}, 32);
        check_all("R4 bad crc discarded");
        chk("R4 crc_err set", 64'(crc_err), 64'd1);
        send_good(mkw(3'b000, 2'd1, 16'h2222));
        chk("R4 crc_err sticky", 64'(crc_err), 64'd1);
        crc_en = 1'b0;

        // R6/R7: held loading
        hold_on();
        send_good(mkw(3'b000, 2'd3, 16'hAAAA));
        send_good(mkw(3'b000, 2'd3, 16'hBBBB));
        send_good(mkw(3'b000, 2'd1, 16'hCCCC));
        check_all("R6 outputs frozen while held");
        release_hold();
        check_all("R7 collective transfer, first write kept");

        // R8: clear code and clear strobe
        send_good(mkw(3'b001, 2'd2, 16'h0F0F));
        check_all("R8 clear-code write leaves outputs");
        pulse_clr(4'b0101);
        check_all("R8 masked clear");

        // R8/R7: clear and release in one cycle
        hold_on();
        send_good(mkw(3'b000, 2'd0, 16'h1111));
        send_good(mkw(3'b000, 2'd1, 16'h9999));
        clr_mask = 4'b0001;
        hold_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (6) @(negedge clk);
        exp_out[1] = exp_stg[1];
        exp_out[0] = exp_clr;
        exp_sv = '0;
        check_all("R8 R7 clear beats same-cycle transfer");
        hold_on();
        release_hold();
        check_all("R7 no stale staging after collision");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel < 2) begin
                send_good(mkw(3'($urandom % 2), 2'($urandom), 16'($urandom)));
                check_all("R5 R1 random write");
            end else if (sel == 2) begin
                int nw;
                nw = 1 + int'($urandom % 4);
                hold_on();
                for (int j = 0; j < nw; j++) send_good(mkw(3'b000, 2'($urandom), 16'($urandom)));
                check_all("R6 random held writes");
                release_hold();
                check_all("R7 random release");
            end else begin
                pulse_clr(4'($urandom));
                check_all("R8 random clear");
            end
        end
        finish_run();
    end

endmodule